// File: doc/BRIEF.md
# Sixteen-Byte Two-Wire Serial Memory Slave

This block is a small serial memory that answers on a two-wire open-drain bus (SCL clock from the master, SDA shared data). It holds sixteen bytes in a register array. A master first sends a control byte made of a fixed seven-bit device code and a direction bit. With the direction bit clear, the next byte loads the internal address pointer, and an optional data byte after it is written. With the direction bit set, the slave returns bytes from the pointer onwards for as long as the master acknowledges them.

After a write transfer ends, the block models the write cycle of a non-volatile part. For a fixed number of system clock cycles it refuses its own control byte, so a master can poll for completion. Both bus lines are brought into the system clock domain through flop chains. The SDA output is a single pull-low enable, and the pad outside the block turns it into an open-drain driver.

Top module: `i2c_mem16_slave`

## Requirements
- R1: A start is recognised when SDA falls while SCL is high, and a stop when SDA rises while SCL is high. A start received in the middle of any transfer, a repeated start, aborts that transfer and begins a new control byte.
- R2: Bus bits are shifted most significant bit first. A control byte whose upper seven bits equal 1010000 is acknowledged by pulling SDA low for the ninth clock. Its bit 0 selects read (1) or write (0).
- R3: A control byte with any other device code gets no acknowledge. The slave then ignores the bus, drives nothing and stores nothing until the next start.
- R4: In a write transfer, the byte after the control byte is an address byte. It is acknowledged, and the pointer is loaded from its low four bits, only when its upper four bits are zero. Otherwise it gets no acknowledge, the pointer keeps its value and the rest of the transfer is ignored.
- R5: A data byte following an accepted address byte is acknowledged and written to the addressed location when the stop arrives. Any further data byte in the same transfer gets no acknowledge and is not stored.
- R6: A write transfer that ends after the address byte only sets the pointer. It writes nothing and does not start the busy period.
- R7: A read transfer returns the byte at the pointer. The pointer advances by one, modulo 16, for every byte sent.
- R8: During a read, an acknowledge from the master makes the slave send the next byte, wrapping from address 15 to 0. A not-acknowledge makes the slave release SDA for the rest of the transfer.
- R9: For BUSY_CYCLES system clock cycles after a stop that commits a write, a matching control byte gets no acknowledge. Once that period has passed it is acknowledged again.
- R10: A committed write advances the pointer by one, modulo 16, so a following current-address read returns the next location.
- R11: After reset, SDA is released, the pointer is 0 and every location reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | When 1 the pad pulls SDA low, when 0 it releases the line |

## Verification
On every cycle the checker confirms several properties. SDA is driven only in acknowledge and read-data states, it is released in the idle and ignore states, and the pull-low enable changes only just after an SCL fall, a start or a stop. It also confirms that the busy period begins only at a stop and never overlaps an acknowledged control byte, and that the pointer moves only by one step or by an address load. Data contents, the refusal of bytes after a bad device code or a bad address, pointer wrap in sequential reads and the end of the busy period are shown only by the bench's scenarios, which read the stored bytes back over the bus.

// File: rtl/sm16_pkg.sv
// Shared types for the sixteen-byte serial memory slave.
// Assumes: byte-wide bus transfers.
package sm16_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/sm16_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives the bus events.
// Assumes: both lines idle high; the system clock is much faster than SCL.
module sm16_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr_q;
    logic [STAGES-1:0] sda_sr_q;
    logic              scl_d_q;
    logic              sda_d_q;
    logic              scl_s;

    // Synchroniser chains for both lines, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
        end else begin
            scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_i};
            sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_sr_q[STAGES-1];
    assign sda_s = sda_sr_q[STAGES-1];

    // One-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_d_q <= scl_s;
            sda_d_q <= sda_s;
        end
    end

    // Bus events: clock edges, and data edges while the clock stays high.
    always_comb begin
        scl_rise  = !scl_d_q && scl_s;
        scl_fall  = scl_d_q && !scl_s;
        start_det = scl_d_q && scl_s && sda_d_q && !sda_s;
        stop_det  = scl_d_q && scl_s && !sda_d_q && sda_s;
    end

endmodule

// File: rtl/sm16_regfile.sv
// Byte storage array with one synchronous write port and one combinational read port.
// Assumes: DEPTH is a power of two; contents clear on reset.
module sm16_regfile #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // One storage word, loaded when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sm16_busy_timer.sv
// Counts down the modelled write-cycle time after a write commits.
// Assumes: CYCLES >= 1; a new start while busy reloads the count.
module sm16_busy_timer #(
    parameter int unsigned CYCLES = 1000,
    localparam int unsigned CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_q;

    // Load on commit, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/i2c_mem16_slave.sv
// Two-wire serial memory slave with a sixteen-byte array, pointer and write-busy model.
// Assumes: no clock stretching; SDA is changed by the master only while SCL is low;
// sda_drive_low feeds an open-drain pad.
module i2c_mem16_slave #(
    parameter logic [6:0]  DEV_CODE    = 7'b1010000,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned BUSY_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low
);
    import sm16_pkg::*;

    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              busy;
    logic              commit;
    logic [BYTE_W-1:0] rdata;
    logic [BYTE_W-1:0] rx_next;

    slv_state_e        state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [AW-1:0]     ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic              pend_q;
    logic [BYTE_W-1:0] wbyte_q;
    logic              drive_q;

    sm16_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    sm16_regfile #(
        .DEPTH(DEPTH),
        .DW   (BYTE_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit),
        .waddr(ptr_q),
        .wdata(wbyte_q),
        .raddr(ptr_q),
        .rdata(rdata)
    );

    sm16_busy_timer #(
        .CYCLES(BUSY_CYCLES)
    ) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(commit),
        .busy (busy)
    );

    // A pending data byte is written when the transfer closes with a stop.
    assign commit  = stop_det && pend_q;
    assign rx_next = {rx_q[BYTE_W-2:0], sda_s};

    // Protocol sequencer: shifting, acknowledge decisions, pointer and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            pend_q    <= 1'b0;
            wbyte_q   <= '0;
            drive_q   <= 1'b0;
        end else if (start_det) begin
            state_q   <= ST_CTRL;
            bit_cnt_q <= '0;
            pend_q    <= 1'b0;
            drive_q   <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            drive_q <= 1'b0;
            pend_q  <= 1'b0;
            if (pend_q) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && (bit_cnt_q != CNT_W'(BYTE_W))) begin
                        rx_q      <= rx_next;
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (scl_fall && (bit_cnt_q == CNT_W'(BYTE_W))) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_CTRL) begin
                            if ((rx_q[BYTE_W-1:1] == DEV_CODE) && !busy) begin
                                rw_q    <= rx_q[0];
                                drive_q <= 1'b1;
                                state_q <= ST_CTRL_ACK;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end else if (state_q == ST_ADDR) begin
                            if (rx_q[BYTE_W-1:AW] == '0) begin
                                ptr_q   <= rx_q[AW-1:0];
                                drive_q <= 1'b1;
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end else begin
                            if (!pend_q) begin
                                wbyte_q <= rx_q;
                                pend_q  <= 1'b1;
                                drive_q <= 1'b1;
                                state_q <= ST_WDATA_ACK;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_q      <= rdata;
                            ptr_q     <= ptr_q + 1'b1;
                            drive_q   <= !rdata[BYTE_W-1];
                            bit_cnt_q <= '0;
                            state_q   <= ST_RDATA;
                        end else begin
                            drive_q <= 1'b0;
                            state_q <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        drive_q <= 1'b0;
                        state_q <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
                            drive_q   <= 1'b0;
                            bit_cnt_q <= '0;
                            state_q   <= ST_RACK;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                            drive_q   <= !tx_q[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_q      <= rdata;
                            ptr_q     <= ptr_q + 1'b1;
                            drive_q   <= !rdata[BYTE_W-1];
                            bit_cnt_q <= '0;
                            state_q   <= ST_RDATA;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_drive_low = drive_q;

endmodule

// File: rtl/sm16_checker.sv
// Cycle-level properties of the serial memory slave, bound to its top module.
// Assumes: observes internal sequencer state through the bind connections.
module sm16_checker #(
    parameter int unsigned AW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input sm16_pkg::slv_state_e state,
    input logic                 sda_drive_low,
    input logic                 scl_fall,
    input logic                 start_det,
    input logic                 stop_det,
    input logic                 busy,
    input logic [AW-1:0]        ptr
);
    import sm16_pkg::*;

    // R8
    release_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_drive_low);

    // R2
    drive_only_ack_or_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (state inside {ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

    // R1
    drive_changes_at_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |->
            ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R9
    no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL_ACK) |-> !busy);

    // R9
    busy_begins_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R10
    pointer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ((ptr == AW'($past(ptr) + 1'b1)) || ($past(state) == ST_ADDR)));

endmodule

bind i2c_mem16_slave sm16_checker #(
    .AW(AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .sda_drive_low(sda_drive_low),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .busy         (busy),
    .ptr          (ptr_q)
);

// File: tb/tb_i2c_mem16_slave.sv
`timescale 1ns/1ps
// Directed scenarios driving a bit-level bus master model against the slave.
module tb_i2c_mem16_slave;
    localparam int BUSY = 600;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    wire  sda_bus = sda_m & ~sda_drive_low;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    i2c_mem16_slave #(
        .BUSY_CYCLES(BUSY)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_drive_low(sda_drive_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_bus}; tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(a, k2);
        send_byte(d, k3);
        bus_stop();
        ok = k1 & k2 & k3;
        tick(BUSY + 60);
    endtask

    task automatic set_ptr(input logic [7:0] a, output logic ok);
        logic k1, k2;
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(a, k2);
        bus_stop();
        ok = k1 & k2;
    endtask

    task automatic read_cur(output logic [7:0] b, output logic ok);
        bus_start();
        send_byte(8'hA1, ok);
        recv_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic test_reset();
        logic [7:0] b;
        logic ok;
        chk("R11 SDA released after reset", int'(sda_drive_low), 0);
        read_cur(b, ok);
        chk("R11 read control acked", int'(ok), 1);
        chk("R11 location 0 clear after reset", int'(b), 8'h00);
    endtask

    task automatic test_write_read();
        logic [7:0] b;
        logic ok;
        write_byte(8'h05, 8'h3C, ok);
        chk("R2 R5 write transfer fully acked", int'(ok), 1);
        set_ptr(8'h05, ok);
        chk("R6 address-only transfer acked", int'(ok), 1);
        read_cur(b, ok);
        chk("R7 current-address read data", int'(b), 8'h3C);
        read_cur(b, ok);
        chk("R7 pointer advanced to next location", int'(b), 8'h00);
    endtask

    task automatic test_ptr_after_write();
        logic [7:0] b;
        logic ok;
        write_byte(8'h0A, 8'h11, ok);
        write_byte(8'h09, 8'h22, ok);
        read_cur(b, ok);
        chk("R10 read after write returns next location", int'(b), 8'h11);
    endtask

    task automatic test_seq_wrap();
        logic [7:0] b0, b1, b2, b;
        logic ok;
        write_byte(8'h0E, 8'hA1, ok);
        write_byte(8'h0F, 8'hB2, ok);
        write_byte(8'h00, 8'hC3, ok);
        set_ptr(8'h0E, ok);
        bus_start();
        send_byte(8'hA1, ok);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        chk("R8 SDA released after master NACK", int'(sda_drive_low), 0);
        bus_stop();
        chk("R8 sequential byte at 14", int'(b0), 8'hA1);
        chk("R8 sequential byte at 15", int'(b1), 8'hB2);
        chk("R8 sequential wrap to 0", int'(b2), 8'hC3);
        read_cur(b, ok);
        chk("R7 pointer after sequential read", int'(b), 8'h00);
    endtask

    task automatic test_bad_code();
        logic [7:0] b;
        logic ok, k2, k3;
        bus_start();
        send_byte(8'hA2, ok);
        send_byte(8'h07, k2);
        send_byte(8'h99, k3);
        bus_stop();
        chk("R3 wrong device code not acked", int'(ok), 0);
        chk("R3 following bytes ignored", int'(k2 | k3), 0);
        set_ptr(8'h07, ok);
        read_cur(b, ok);
        chk("R3 nothing stored after wrong code", int'(b), 8'h00);
    endtask

    task automatic test_bad_addr();
        logic [7:0] b;
        logic ok, k1, k2, k3;
        write_byte(8'h08, 8'h44, ok);
        set_ptr(8'h08, ok);
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(8'h37, k2);
        send_byte(8'h99, k3);
        bus_stop();
        chk("R4 address with nonzero upper nibble not acked", int'(k2), 0);
        chk("R4 data after bad address ignored", int'(k3), 0);
        tick(BUSY + 60);
        read_cur(b, ok);
        chk("R4 pointer unchanged by bad address", int'(b), 8'h44);
    endtask

    task automatic test_extra_data();
        logic [7:0] b;
        logic ok, k1, k2, k3, k4;
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(8'h0C, k2);
        send_byte(8'h5E, k3);
        send_byte(8'h77, k4);
        bus_stop();
        tick(BUSY + 60);
        chk("R5 first data byte acked", int'(k3), 1);
        chk("R5 second data byte not acked", int'(k4), 0);
        set_ptr(8'h0C, ok);
        read_cur(b, ok);
        chk("R5 first data byte stored", int'(b), 8'h5E);
        read_cur(b, ok);
        chk("R5 second data byte not stored", int'(b), 8'h00);
    endtask

    task automatic test_busy();
        logic ok, k1, k2, k3;
        set_ptr(8'h03, ok);
        bus_start();
        send_byte(8'hA0, k1);
        bus_stop();
        chk("R6 address-only transfer leaves slave ready", int'(k1), 1);
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(8'h02, k2);
        send_byte(8'h66, k3);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ok);
        bus_stop();
        chk("R9 control refused during write cycle", int'(ok), 0);
        tick(BUSY + 100);
        bus_start();
        send_byte(8'hA0, ok);
        bus_stop();
        chk("R9 control accepted after write cycle", int'(ok), 1);
    endtask

    task automatic test_restart();
        logic [7:0] b;
        logic ok, k1, k2, k3;
        write_byte(8'h04, 8'h4D, ok);
        set_ptr(8'h00, ok);
        bus_start();
        send_byte(8'hA0, k1);
        send_byte(8'h04, k2);
        bus_start();
        send_byte(8'hA1, k3);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R1 repeated start accepted", int'(k3), 1);
        chk("R1 read after repeated start", int'(b), 8'h4D);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        test_reset();
        test_write_read();
        test_ptr_after_write();
        test_seq_wrap();
        test_bad_code();
        test_bad_addr();
        test_extra_data();
        test_busy();
        test_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule